// File: doc/BRIEF.md
# Strap-Sampled Debug Probe Multiplexer

This block drives an 8-bit debug observation port. After power-good rises, or after a system reset, its four low pins are left undriven so that board pull resistors set their level. A delay counter on the reference clock runs for a fixed number of cycles. When it expires, the block latches those four pins once as a mode code and then drives all eight pins as outputs.

The latched code selects what the port shows. One code keeps the port low with no toggling. A second code routes six internal clocks, framed by two constant-high bits. A third code routes a set of sync, index and sequencing status signals. Any other code falls back to the quiet all-low output.

A software register holds an override valid bit and a 4-bit mode. While the valid bit is set, the register mode replaces the strap code. The captured code and a done flag are brought out so software can read them.

Top module: `dbg_probe_mux`

## Requirements
- R1: With `rst_n` and `pwr_ok` high, `strap_done` stays low for the first DELAY_CYC-1 rising edges and goes high on rising edge number DELAY_CYC, counted from the first edge that sees both high. On that edge `strap_code` takes the value of `pin_in`.
- R2: Once `strap_done` is high, later changes on `pin_in` do not alter `strap_code`.
- R3: `pwr_ok` low at a rising edge, or `rst_n` low, clears `strap_done` and restarts the delay. A new capture then follows the R1 timing.
- R4: With effective code 4'b0000, `pin_out` is 8'h00 and `pin_oe` is 8'hFF once sampling is done.
- R5: With effective code 4'b0101, `pin_out[0]` and `pin_out[7]` are 1 and `pin_out[k]` equals `clk_taps[k-1]` for k = 1..6.
- R6: With effective code 4'b1000, `pin_out[k]` equals `cal_sig[k]` for all k. The order of `cal_sig` is: bit 0 vertical sync, 1 delayed wheel index, 2 sequence index, 3 wheel spoke marker, 4 wheel revolution marker, 5..7 reset-sequence auxiliary bits 0..2.
- R7: While `strap_done` is low, `pin_oe` is 8'hF0 (bits 3:0 released, bits 7:4 driven) and `pin_out` is 8'h00, whatever the override register holds.
- R8: Any effective code other than 4'b0000, 4'b0101 or 4'b1000 gives `pin_out` = 8'h00.
- R9: A rising edge with `sw_wr` high loads `sw_valid` and `sw_mode` into the override register, and the port reflects the new selection right after that edge. With valid set, `sw_mode` is the effective code. With valid clear, the strap code is the effective code. `rst_n` clears the register.
- R10: `strap_code` and `strap_done` report the latched code and the sampling-done state. `strap_code` is 4'b0000 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| pwr_ok | input | 1 | Power-good level; low restarts strap sampling |
| pin_in | input | 4 | Pad input level of port bits 3:0 (strap values) |
| clk_taps | input | 6 | Internal clocks shown in clock-debug view |
| cal_sig | input | 8 | Calibration and sequencing status signals |
| sw_wr | input | 1 | Write strobe of the override register |
| sw_valid | input | 1 | Override valid bit to write |
| sw_mode | input | 4 | Override mode code to write |
| pin_out | output | 8 | Port output values |
| pin_oe | output | 8 | Per-bit output enables |
| strap_code | output | 4 | Latched strap code |
| strap_done | output | 1 | Strap sampling has completed |

## Verification
On every cycle, the assertions check three things. The latched code stays frozen while sampling is done. The released-pin state holds before sampling. The quiet view always gives an all-low port. They also check that an override write becomes the effective code on the next edge.

Only the bench scenarios can show the rest. These are the exact cycle on which the delay expires, the bit placement of the clock and calibration views, and the fallback for unlisted codes. They also cover the reversion to the strap code when the override is cleared, and a second capture after power-good drops.

// File: rtl/dbg_probe_pkg.sv
package dbg_probe_pkg;

    localparam int PORT_W  = 8;
    localparam int STRAP_W = 4;
    localparam int TAP_N   = 6;

    localparam logic [STRAP_W-1:0] CODE_QUIET = 4'b0000;
    localparam logic [STRAP_W-1:0] CODE_CLKS  = 4'b0101;
    localparam logic [STRAP_W-1:0] CODE_CALIB = 4'b1000;

    typedef enum logic [1:0] {
        VIEW_QUIET = 2'd0,
        VIEW_CLKS  = 2'd1,
        VIEW_CALIB = 2'd2
    } view_e;

    typedef struct packed {
        logic               valid;
        logic [STRAP_W-1:0] mode;
    } ovr_reg_t;

    function automatic view_e decode_view(input logic [STRAP_W-1:0] code);
        view_e v;
        case (code)
            CODE_CLKS:  v = VIEW_CLKS;
            CODE_CALIB: v = VIEW_CALIB;
            default:    v = VIEW_QUIET;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/strap_sampler.sv
module strap_sampler
    import dbg_probe_pkg::*;
#(
    parameter int DELAY_CYC = 150
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_ok,
    input  logic [STRAP_W-1:0] pin_in,
    output logic [STRAP_W-1:0] code,
    output logic               done
);

    localparam int CNT_W = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic               done;
        logic [STRAP_W-1:0] code;
    } smp_t;

    smp_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pwr_ok) begin
            st_d.cnt  = '0;
            st_d.done = 1'b0;
        end else if (!st_q.done) begin
            if (st_q.cnt == LAST) begin
                st_d.done = 1'b1;
                st_d.code = pin_in;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, done: 1'b0, code: CODE_QUIET};
        else        st_q <= st_d;
    end

    assign code = st_q.code;
    assign done = st_q.done;

    assert_code_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && pwr_ok) |=> $stable(st_q.code));

    assert_done_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && pwr_ok) |=> st_q.done);

    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

    assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (!st_q.done && st_q.cnt == '0));

endmodule

// File: rtl/mode_resolver.sv
module mode_resolver
    import dbg_probe_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_wr,
    input  logic               sw_valid,
    input  logic [STRAP_W-1:0] sw_mode,
    input  logic [STRAP_W-1:0] strap_code,
    output logic [STRAP_W-1:0] eff_code,
    output view_e              view
);

    ovr_reg_t ovr_d, ovr_q;

    always_comb begin
        ovr_d = ovr_q;
        if (sw_wr) begin
            ovr_d.valid = sw_valid;
            ovr_d.mode  = sw_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovr_q <= '{valid: 1'b0, mode: CODE_QUIET};
        else        ovr_q <= ovr_d;
    end

    assign eff_code = ovr_q.valid ? ovr_q.mode : strap_code;
    assign view     = decode_view(eff_code);

    assert_override_applies_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && sw_valid) |=> (eff_code == $past(sw_mode)));

    assert_override_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && !sw_valid) |=> (eff_code == strap_code));

endmodule

// File: rtl/probe_mux.sv
module probe_mux
    import dbg_probe_pkg::*;
(
    input  view_e             view,
    input  logic              done,
    input  logic [TAP_N-1:0]  clk_taps,
    input  logic [PORT_W-1:0] cal_sig,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);

    localparam int LOW_W = STRAP_W;

    logic [PORT_W-1:0] clk_view;

    assign clk_view[0]        = 1'b1;
    assign clk_view[PORT_W-1] = 1'b1;
    for (genvar k = 0; k < TAP_N; k++) begin : g_tap
        assign clk_view[k+1] = clk_taps[k];
    end

    always_comb begin
        pin_oe  = {{(PORT_W-LOW_W){1'b1}}, {LOW_W{1'b0}}};
        pin_out = '0;
        if (done) begin
            pin_oe = '1;
            case (view)
                VIEW_CLKS:  pin_out = clk_view;
                VIEW_CALIB: pin_out = cal_sig;
                default:    pin_out = '0;
            endcase
        end
    end

endmodule

// File: rtl/dbg_probe_mux.sv
module dbg_probe_mux
    import dbg_probe_pkg::*;
#(
    parameter int DELAY_CYC = 150
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_ok,
    input  logic [3:0] pin_in,
    input  logic [5:0] clk_taps,
    input  logic [7:0] cal_sig,
    input  logic       sw_wr,
    input  logic       sw_valid,
    input  logic [3:0] sw_mode,
    output logic [7:0] pin_out,
    output logic [7:0] pin_oe,
    output logic [3:0] strap_code,
    output logic       strap_done
);

    logic [STRAP_W-1:0] eff_code;
    view_e              view;

    strap_sampler #(.DELAY_CYC(DELAY_CYC)) i_sampler (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_ok (pwr_ok),
        .pin_in (pin_in),
        .code   (strap_code),
        .done   (strap_done)
    );

    mode_resolver i_resolver (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_wr      (sw_wr),
        .sw_valid   (sw_valid),
        .sw_mode    (sw_mode),
        .strap_code (strap_code),
        .eff_code   (eff_code),
        .view       (view)
    );

    probe_mux i_mux (
        .view     (view),
        .done     (strap_done),
        .clk_taps (clk_taps),
        .cal_sig  (cal_sig),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    assert_pins_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_done |-> (pin_oe == 8'hF0 && pin_out == 8'h00));

    assert_quiet_view_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_done && view == VIEW_QUIET) |-> (pin_out == 8'h00 && pin_oe == 8'hFF));

    assert_clk_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_done && view == VIEW_CLKS) |-> (pin_out[0] && pin_out[7]));

endmodule

// File: tb/test_dbg_probe_mux.sv
module test_dbg_probe_mux;

    localparam int DLY = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_ok = 1'b0;
    logic [3:0] pin_in = 4'b0000;
    logic [5:0] clk_taps = '0;
    logic [7:0] cal_sig = '0;
    logic       sw_wr = 1'b0;
    logic       sw_valid = 1'b0;
    logic [3:0] sw_mode = '0;
    logic [7:0] pin_out, pin_oe;
    logic [3:0] strap_code;
    logic       strap_done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    dbg_probe_mux #(.DELAY_CYC(DLY)) i_dbg_probe_mux (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .pin_in(pin_in),
        .clk_taps(clk_taps), .cal_sig(cal_sig), .sw_wr(sw_wr),
        .sw_valid(sw_valid), .sw_mode(sw_mode), .pin_out(pin_out),
        .pin_oe(pin_oe), .strap_code(strap_code), .strap_done(strap_done)
    );

    // mode, taps, cal, expected pin_out
    typedef struct packed {
        logic [3:0] mode;
        logic [5:0] taps;
        logic [7:0] cal;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{4'b0000, 6'h3F, 8'hA5, 8'h00},  // R4
        '{4'b0101, 6'h00, 8'hFF, 8'h81},  // R5
        '{4'b0101, 6'h2A, 8'h00, 8'hD5},  // R5
        '{4'b0101, 6'h3F, 8'h00, 8'hFF},  // R5
        '{4'b1000, 6'h3F, 8'h3C, 8'h3C},  // R6
        '{4'b1000, 6'h00, 8'h81, 8'h81},  // R6
        '{4'b0011, 6'h3F, 8'hFF, 8'h00},  // R8
        '{4'b1111, 6'h3F, 8'hFF, 8'h00},  // R8
        '{4'b0001, 6'h3F, 8'hFF, 8'h00},  // R8
        '{4'b1001, 6'h3F, 8'hFF, 8'h00}   // R8
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic sw_write(input logic v, input logic [3:0] m);
        @(negedge clk);
        sw_wr = 1'b1; sw_valid = v; sw_mode = m;
        @(negedge clk);
        sw_wr = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual %0d expected below 100000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        // reset state (R10, R7)
        edges(2);
        chk("R10 reset code", 32'(strap_code), 32'h0);
        chk("R10 reset done", 32'(strap_done), 32'h0);
        chk("R7 reset oe", 32'(pin_oe), 32'hF0);
        chk("R7 reset out", 32'(pin_out), 32'h00);

        // R1: first capture of 0101
        pin_in = 4'b0101; clk_taps = 6'h2A; cal_sig = 8'h5A;
        rst_n = 1'b1; pwr_ok = 1'b1;
        edges(DLY - 1);
        chk("R1 not yet done", 32'(strap_done), 32'h0);
        sw_wr = 1'b1; sw_valid = 1'b1; sw_mode = 4'b1000; // R7 override ignored before done
        edges(1);
        sw_wr = 1'b0;
        chk("R1 done on edge DELAY", 32'(strap_done), 32'h1);
        chk("R1 captured code", 32'(strap_code), 32'h5);
        chk("R9 override active", 32'(pin_out), 32'h5A);
        sw_write(1'b0, 4'b0000);
        chk("R9 revert to strap clk view", 32'(pin_out), 32'hD5);
        chk("R4 oe after done", 32'(pin_oe), 32'hFF);

        // R2: strap pins change later
        pin_in = 4'b1000;
        edges(5);
        chk("R2 code frozen", 32'(strap_code), 32'h5);
        chk("R2 output unchanged", 32'(pin_out), 32'hD5);

        // table walk through override (R4 R5 R6 R8 R9)
        for (int i = 0; i < NV; i++) begin
            clk_taps = VECS[i].taps; cal_sig = VECS[i].cal;
            sw_write(1'b1, VECS[i].mode);
            chk($sformatf("R9 vec %0d mode %b", i, VECS[i].mode), 32'(pin_out), 32'(VECS[i].exp));
        end
        sw_write(1'b0, 4'b0000);

        // R3: power-good drop, recapture 1000
        clk_taps = 6'h15; cal_sig = 8'hC3; pin_in = 4'b1000;
        pwr_ok = 1'b0;
        edges(1);
        chk("R3 done cleared", 32'(strap_done), 32'h0);
        chk("R7 released again", 32'(pin_oe), 32'hF0);
        pwr_ok = 1'b1;
        edges(DLY - 1);
        chk("R3 still waiting", 32'(strap_done), 32'h0);
        edges(1);
        chk("R3 recaptured", 32'(strap_code), 32'h8);
        chk("R6 calib view", 32'(pin_out), 32'hC3);

        // R3/R8: system reset, unlisted code 0011; R9 register cleared
        sw_write(1'b1, 4'b0101);
        @(negedge clk);
        rst_n = 1'b0; pin_in = 4'b0011; clk_taps = 6'h3F; cal_sig = 8'hFF;
        edges(1);
        chk("R3 reset clears done", 32'(strap_done), 32'h0);
        rst_n = 1'b1;
        edges(DLY);
        chk("R3 capture after reset", 32'(strap_code), 32'h3);
        chk("R8 unlisted code quiet", 32'(pin_out), 32'h00);
        chk("R4 quiet oe", 32'(pin_oe), 32'hFF);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule